// File: doc/BRIEF.md
# ISA-style bus master cycle generator

This block sits between a simple host request port and a 16-bit ISA-style expansion bus. Each host request gives a 24-bit address, a memory-or-I/O flag, a byte-or-word size, a read-or-write flag and 16 bits of write data. The block runs the request as one or two bus cycles. Each bus cycle has four parts: an address-latch pulse, an address phase, a command phase with exactly one read or write strobe active, and a recovery clock. While it runs, the block holds the address and the byte-high enable steady.

After the latch pulse, the block samples a device-width input. A memory word request to a target that is only 8 bits wide is run as two byte cycles, at the request address and at the next address. Both halves use the low data lane. A ready input stretches the command phase, and a counter flags a stretch that lasts too long. Two sets of memory strobes are driven. The general memory strobes cover every memory cycle. The low-memory strobes fire only when the address of the current cycle is below 1 MB. The I/O strobes are held off while a refresh indication is high. At the end of a read, the returned bytes are assembled into one 16-bit result and a done pulse is given.

Top module: `isa_cycle_master`

## Requirements
- R1: Every bus cycle begins with `bus_latch` high for exactly one clock. From that clock until the cycle's recovery clock ends, `bus_addr` and `bus_bhe_n` do not change.
- R2: Memory cycles drive the full 24-bit address. I/O cycles drive only the low 16 request address bits, and bits 23:16 are zero.
- R3: `mem_rd_n` or `mem_wr_n` goes low in every memory cycle. `lo_mem_rd_n` or `lo_mem_wr_n` goes low only when that cycle's address is below 24'h100000. No more than one of the four general strobes is low at any time.
- R4: `bus_bhe_n` is low in every cycle of a word request. For a byte request it is low exactly when address bit 0 is 1.
- R5: `dev16_n` is sampled in the clock after the latch pulse. A memory word request that sees `dev16_n`=1 runs two cycles: first at address A, then at A+1, with the carry wrapping at 24 bits. Every other request runs one cycle, and this includes I/O word requests.
- R6: During a write strobe, data is steered as follows. In a split write, bits 7:0 carry `req_wdata[7:0]` in the first cycle and `req_wdata[15:8]` in the second. A byte write carries `req_wdata[7:0]` on both lanes. An unsplit word write carries all 16 bits.
- R7: After a read, `rd_data` holds the result. For a split read it is {second-cycle bits 7:0, first-cycle bits 7:0}. For an unsplit word read it is `bus_rdata`. For a byte read it is the lane picked by address bit 0 (bit 0 = 1 picks 15:8), zero-extended.
- R8: A strobe stays low for at least CMD_CYC (default 2) clocks. After that it stays low until `bus_rdy` is sampled high at a clock edge.
- R9: `io_rd_n` and `io_wr_n` stay high in every clock where `refresh` is high. The cycle itself still completes.
- R10: `timeout` is set once `bus_rdy` has been sampled low for more than TMO_LIMIT (default 625, which is 2.5 us at 250 MHz) consecutive command-phase clocks. It stays set until the next request is accepted.
- R11: After reset, `busy`, `done`, `timeout` and `bus_latch` are low and every strobe is high. `done` is a one-clock pulse in the final recovery clock. `busy` is low in the clock after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Assembled read result |
| timeout | output | 1 | Ready held low too long |
| bus_latch | output | 1 | Address-latch pulse |
| bus_addr | output | 24 | Bus address |
| bus_bhe_n | output | 1 | Byte-high enable, active low |
| bus_wdata | output | 16 | Steered write data |
| bus_rdata | input | 16 | Read data from the bus |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| lo_mem_rd_n | output | 1 | Memory read strobe for addresses below 1 MB |
| lo_mem_wr_n | output | 1 | Memory write strobe for addresses below 1 MB |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| dev16_n | input | 1 | Low = 16-bit memory target present |
| bus_rdy | input | 1 | Channel ready; low stretches the strobe |
| refresh | input | 1 | Refresh in progress; blocks the I/O strobes |

## Verification
Ready stretching and the timeout counter act in the same strobe window. The bench holds `bus_rdy` low for a chosen number of strobe clocks and then releases it. It checks that the strobe lasted exactly that long, and that `timeout` is set only when the hold went past the limit. A second overlap, between splitting and the low-memory decode, comes up in the sweep. A split word at 24'h0FFFFF must give a first half with a low-memory strobe and a second half without one. A split word at 24'hFFFFFF wraps to address 0, where the low-memory strobe returns. Each of these is judged per cycle against addresses the bench computes itself.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LATCH = 3'd1,
    S_ADDR  = 3'd2,
    S_CMD   = 3'd3,
    S_END   = 3'd4
  } cyc_state_e;

  typedef struct packed {
    logic              write;
    logic              mem;
    logic              word;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } cyc_req_t;

  // Address put on the bus for one cycle of a request.
  function automatic logic [ADDR_W-1:0] cycle_addr(
      input logic [ADDR_W-1:0] base, input logic mem, input logic second, input int io_aw);
    logic [ADDR_W-1:0] mask;
    mask = (ADDR_W'(1) << io_aw) - ADDR_W'(1);
    if (mem) return base + ADDR_W'(second);
    return base & mask;
  endfunction

  // Address lies below the low-memory window limit.
  function automatic logic in_low_window(input logic [ADDR_W-1:0] a, input int lo_aw);
    return (a >> lo_aw) == '0;
  endfunction

  // Byte-high enable level for a cycle.
  function automatic logic bhe_level_n(input logic word, input logic a0);
    return word ? 1'b0 : ~a0;
  endfunction

  // Write data steering onto the bus lanes.
  function automatic logic [DATA_W-1:0] steer_wdata(
      input logic word, input logic split, input logic second, input logic [DATA_W-1:0] wd);
    logic [7:0] b;
    if (split) begin
      b = second ? wd[15:8] : wd[7:0];
      return {b, b};
    end
    if (word) return wd;
    return {wd[7:0], wd[7:0]};
  endfunction

  // Merge one bus read into the assembled result.
  function automatic logic [DATA_W-1:0] merge_rdata(
      input logic [DATA_W-1:0] prev, input logic [DATA_W-1:0] rd,
      input logic word, input logic split, input logic second, input logic a0);
    if (split) return second ? {rd[7:0], prev[7:0]} : {8'h00, rd[7:0]};
    if (word) return rd;
    return a0 ? {8'h00, rd[15:8]} : {8'h00, rd[7:0]};
  endfunction

endpackage

// File: rtl/isa_cyc_seq.sv
module isa_cyc_seq
  import isa_cyc_pkg::*;
#(
  parameter int CMD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       word_mem,
  input  logic       dev16_n,
  input  logic       bus_rdy,
  output cyc_state_e state,
  output logic       second,
  output logic       split,
  output logic       accept,
  output logic       cmd_exit,
  output logic       last_end
);

  localparam int CW = $clog2(CMD_CYC + 1);
  localparam logic [CW-1:0] CMD_LAST = CW'(CMD_CYC - 1);

  cyc_state_e state_d;
  logic [CW-1:0] cmd_cnt;

  assign accept   = (state == S_IDLE) && req_valid;
  assign cmd_exit = (state == S_CMD) && (cmd_cnt >= CMD_LAST) && bus_rdy;
  assign last_end = (state == S_END) && !(split && !second);

  always_comb begin
    state_d = state;
    unique case (state)
      S_IDLE:  if (req_valid) state_d = S_LATCH;
      S_LATCH: state_d = S_ADDR;
      S_ADDR:  state_d = S_CMD;
      S_CMD:   if (cmd_exit) state_d = S_END;
      S_END:   state_d = last_end ? S_IDLE : S_LATCH;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      second  <= 1'b0;
      split   <= 1'b0;
      cmd_cnt <= '0;
    end else begin
      state <= state_d;
      if (accept) begin
        second <= 1'b0;
        split  <= 1'b0;
      end
      if (state == S_ADDR) begin
        cmd_cnt <= '0;
        if (!second) split <= word_mem & dev16_n;
      end
      if (state == S_CMD && cmd_cnt < CMD_LAST) cmd_cnt <= cmd_cnt + CW'(1);
      if (state == S_END && !last_end) second <= 1'b1;
    end
  end

endmodule

// File: rtl/isa_cyc_steer.sv
module isa_cyc_steer
  import isa_cyc_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter int LO_AW = 20
) (
  input  logic              mem,
  input  logic              word,
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] wdata,
  input  logic              second,
  input  logic              split,
  output logic [ADDR_W-1:0] addr,
  output logic              bhe_n,
  output logic [DATA_W-1:0] lane_wdata,
  output logic              low_mem
);

  always_comb begin
    addr       = cycle_addr(base, mem, second, IO_AW);
    bhe_n      = bhe_level_n(word, addr[0]);
    lane_wdata = steer_wdata(word, split, second, wdata);
    low_mem    = mem & in_low_window(addr, LO_AW);
  end

endmodule

// File: rtl/isa_cyc_rdy_timer.sv
module isa_cyc_rdy_timer #(
  parameter int TMO_LIMIT = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_cmd,
  input  logic bus_rdy,
  output logic tmo_hit,
  output logic timeout
);

  localparam int TW = $clog2(TMO_LIMIT + 1);
  localparam logic [TW-1:0] LIMIT = TW'(TMO_LIMIT);

  logic [TW-1:0] low_cnt;
  logic          low_now;

  assign low_now = in_cmd & ~bus_rdy;
  assign tmo_hit = low_now && (low_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      timeout <= 1'b0;
    end else begin
      if (!low_now) low_cnt <= '0;
      else if (low_cnt != LIMIT) low_cnt <= low_cnt + TW'(1);
      if (start) timeout <= 1'b0;
      else if (tmo_hit) timeout <= 1'b1;
    end
  end

endmodule

// File: rtl/isa_cycle_master.sv
module isa_cycle_master
  import isa_cyc_pkg::*;
#(
  parameter int CMD_CYC   = 2,
  parameter int TMO_LIMIT = 625,
  parameter int IO_AW     = 16,
  parameter int LO_AW     = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_mem,
  input  logic        req_word,
  input  logic [23:0] req_addr,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        timeout,
  output logic        bus_latch,
  output logic [23:0] bus_addr,
  output logic        bus_bhe_n,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata,
  output logic        mem_rd_n,
  output logic        mem_wr_n,
  output logic        lo_mem_rd_n,
  output logic        lo_mem_wr_n,
  output logic        io_rd_n,
  output logic        io_wr_n,
  input  logic        dev16_n,
  input  logic        bus_rdy,
  input  logic        refresh
);

  cyc_req_t   req_q;
  cyc_state_e state;
  logic       second, split, accept, cmd_exit, last_end;
  logic       in_cmd, in_hold, low_mem, tmo_hit;
  logic       rd_cyc, wr_cyc;

  isa_cyc_seq #(.CMD_CYC(CMD_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .word_mem (req_q.word & req_q.mem),
    .dev16_n  (dev16_n),
    .bus_rdy  (bus_rdy),
    .state    (state),
    .second   (second),
    .split    (split),
    .accept   (accept),
    .cmd_exit (cmd_exit),
    .last_end (last_end)
  );

  isa_cyc_steer #(.IO_AW(IO_AW), .LO_AW(LO_AW)) u_steer (
    .mem       (req_q.mem),
    .word      (req_q.word),
    .base      (req_q.addr),
    .wdata     (req_q.wdata),
    .second    (second),
    .split     (split),
    .addr      (bus_addr),
    .bhe_n     (bus_bhe_n),
    .lane_wdata(bus_wdata),
    .low_mem   (low_mem)
  );

  isa_cyc_rdy_timer #(.TMO_LIMIT(TMO_LIMIT)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .in_cmd (in_cmd),
    .bus_rdy(bus_rdy),
    .tmo_hit(tmo_hit),
    .timeout(timeout)
  );

  // Named phase events for the checker.
  assign in_cmd  = (state == S_CMD);
  assign in_hold = (state == S_ADDR) || (state == S_CMD) || (state == S_END);
  assign rd_cyc  = in_cmd & ~req_q.write;
  assign wr_cyc  = in_cmd &  req_q.write;

  assign bus_latch   = (state == S_LATCH);
  assign busy        = (state != S_IDLE);
  assign done        = last_end;
  assign mem_rd_n    = ~(rd_cyc & req_q.mem);
  assign mem_wr_n    = ~(wr_cyc & req_q.mem);
  assign lo_mem_rd_n = ~(rd_cyc & low_mem);
  assign lo_mem_wr_n = ~(wr_cyc & low_mem);
  assign io_rd_n     = ~(rd_cyc & ~req_q.mem & ~refresh);
  assign io_wr_n     = ~(wr_cyc & ~req_q.mem & ~refresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      rd_data <= '0;
    end else begin
      if (accept) begin
        req_q.write <= req_write;
        req_q.mem   <= req_mem;
        req_q.word  <= req_word;
        req_q.addr  <= req_addr;
        req_q.wdata <= req_wdata;
      end
      if (cmd_exit && !req_q.write)
        rd_data <= merge_rdata(rd_data, bus_rdata, req_q.word, split, second, bus_addr[0]);
    end
  end

endmodule

// File: rtl/isa_cycle_master_chk.sv
module isa_cycle_master_chk #(
  parameter int LO_AW = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_latch,
  input logic [23:0] bus_addr,
  input logic        bus_bhe_n,
  input logic        mem_rd_n,
  input logic        mem_wr_n,
  input logic        lo_mem_rd_n,
  input logic        lo_mem_wr_n,
  input logic        io_rd_n,
  input logic        io_wr_n,
  input logic        refresh,
  input logic        bus_rdy,
  input logic        done,
  input logic        timeout,
  input logic        in_cmd,
  input logic        in_hold
);

  p_latch_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_latch |=> !bus_latch);

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> ($stable(bus_addr) && $stable(bus_bhe_n)));

  p_lomem_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_mem_rd_n |-> (!mem_rd_n && ((bus_addr >> LO_AW) == '0)));

  p_lomem_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_mem_wr_n |-> (!mem_wr_n && ((bus_addr >> LO_AW) == '0)));

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) <= 1);

  p_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cmd && !bus_rdy) |=> in_cmd);

  p_io_refresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> (io_rd_n && io_wr_n));

  p_tmo_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(in_cmd && !bus_rdy));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind isa_cycle_master isa_cycle_master_chk #(.LO_AW(LO_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_latch  (bus_latch),
  .bus_addr   (bus_addr),
  .bus_bhe_n  (bus_bhe_n),
  .mem_rd_n   (mem_rd_n),
  .mem_wr_n   (mem_wr_n),
  .lo_mem_rd_n(lo_mem_rd_n),
  .lo_mem_wr_n(lo_mem_wr_n),
  .io_rd_n    (io_rd_n),
  .io_wr_n    (io_wr_n),
  .refresh    (refresh),
  .bus_rdy    (bus_rdy),
  .done       (done),
  .timeout    (timeout),
  .in_cmd     (in_cmd),
  .in_hold    (in_hold)
);

// File: tb/isa_cycle_master_tb.sv
`timescale 1ns/1ps
module isa_cycle_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, timeout, bus_latch, bus_bhe_n;
  logic [15:0] rd_data, bus_wdata, bus_rdata;
  logic [23:0] bus_addr;
  logic        mem_rd_n, mem_wr_n, lo_mem_rd_n, lo_mem_wr_n, io_rd_n, io_wr_n;
  logic        dev16_n = 1'b0, bus_rdy = 1'b1, refresh = 1'b0;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  isa_cycle_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .timeout(timeout),
    .bus_latch(bus_latch), .bus_addr(bus_addr), .bus_bhe_n(bus_bhe_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .lo_mem_rd_n(lo_mem_rd_n), .lo_mem_wr_n(lo_mem_wr_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .dev16_n(dev16_n), .bus_rdy(bus_rdy),
    .refresh(refresh)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // Target model: an 8-bit target mirrors its byte on both lanes.
  always_comb begin
    if (dev16_n) bus_rdata = {pat(bus_addr), pat(bus_addr)};
    else         bus_rdata = {pat(bus_addr | 24'h1), pat(bus_addr & ~24'h1)};
  end

  function automatic logic [23:0] pick_addr(input int i);
    case (i)
      0: return 24'h000000;
      1: return 24'h000001;
      2: return 24'h0FFFFE;
      3: return 24'h0FFFFF;
      4: return 24'h100000;
      5: return 24'hFFFFFF;
      default: return 24'h3C5A7B;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-request observations
  int          o_nlat, o_stb;
  logic [23:0] o_addr [2];
  logic        o_bhe [2], o_mem [2], o_lo [2], o_io [2];
  logic [15:0] o_wd [2];
  logic        o_moved, o_done, o_tmo, o_busy_after;
  logic [15:0] o_rd;

  task automatic run_req(input bit mem, input bit wr, input bit word, input bit dv,
                         input logic [23:0] a, input logic [15:0] wd,
                         input int hold_k, input bit rf);
    bit any;
    int idx;
    o_nlat = 0; o_stb = 0; o_moved = 0; o_done = 0;
    for (int k = 0; k < 2; k++) begin
      o_addr[k] = '0; o_bhe[k] = 1; o_mem[k] = 0; o_lo[k] = 0; o_io[k] = 0; o_wd[k] = '0;
    end
    @(negedge clk);
    dev16_n = dv; refresh = rf; bus_rdy = (hold_k == 0);
    req_mem = mem; req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 5000 && !o_done; cyc++) begin
      if (bus_latch) begin
        if (o_nlat < 2) begin
          o_addr[o_nlat] = bus_addr;
          o_bhe[o_nlat] = bus_bhe_n;
        end
        o_nlat++;
      end
      idx = (o_nlat > 0 && o_nlat <= 2) ? o_nlat - 1 : 0;
      any = !mem_rd_n || !mem_wr_n || !io_rd_n || !io_wr_n;
      if (!mem_rd_n || !mem_wr_n) o_mem[idx] = 1;
      if (!lo_mem_rd_n || !lo_mem_wr_n) o_lo[idx] = 1;
      if (!io_rd_n || !io_wr_n) o_io[idx] = 1;
      if (any) begin
        o_stb++;
        if (bus_addr != o_addr[idx] || bus_bhe_n != o_bhe[idx]) o_moved = 1;
        if (!mem_wr_n || !io_wr_n) o_wd[idx] = bus_wdata;
        if (hold_k > 0 && o_stb >= hold_k) bus_rdy = 1'b1;
      end
      if (done) begin
        o_done = 1;
        o_rd = rd_data;
        o_tmo = timeout;
      end else begin
        @(negedge clk);
      end
    end
    @(negedge clk);
    o_busy_after = busy || done;
    bus_rdy = 1'b1;
    refresh = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !timeout && !bus_latch, "R11 reset flags",
        {busy, done, timeout, bus_latch}, 0);
    chk({mem_rd_n, mem_wr_n, lo_mem_rd_n, lo_mem_wr_n, io_rd_n, io_wr_n} == 6'h3F,
        "R11 reset strobes", {mem_rd_n, mem_wr_n, lo_mem_rd_n, lo_mem_wr_n, io_rd_n, io_wr_n}, 6'h3F);
    rst_n = 1'b1;

    // Sweep of space, direction, size, target width and address corners
    for (int mi = 0; mi < 2; mi++)
    for (int wi = 0; wi < 2; wi++)
    for (int zi = 0; zi < 2; zi++)
    for (int di = 0; di < 2; di++)
    for (int ai = 0; ai < 7; ai++) begin
      logic [23:0] base, ea, pa;
      logic [15:0] wd, erd, ewd;
      bit split;
      int ncyc;
      base = pick_addr(ai);
      wd = 16'hA500 ^ 16'(ai * 16'h1337 + mi * 7 + wi * 3 + zi * 11 + di);
      split = mi[0] && zi[0] && di[0];
      ncyc = split ? 2 : 1;
      ea = mi[0] ? base : {8'h00, base[15:0]};
      run_req(mi[0], wi[0], zi[0], di[0], base, wd, 0, 0);
      chk(o_done, "R11 done seen", 32'(o_done), 1);
      chk(!o_busy_after, "R11 idle after done", 32'(o_busy_after), 0);
      chk(o_nlat == ncyc, "R5 cycle count", o_nlat, ncyc);
      chk(!o_moved, "R1 address held during strobe", 32'(o_moved), 0);
      for (int k = 0; k < ncyc; k++) begin
        pa = ea + 24'(k);
        chk(o_addr[k] == pa, "R2 cycle address", o_addr[k], pa);
        chk(o_bhe[k] == (zi[0] ? 1'b0 : ~pa[0]), "R4 byte-high enable",
            o_bhe[k], zi[0] ? 1'b0 : ~pa[0]);
        chk(o_mem[k] == mi[0], "R3 memory strobe", o_mem[k], mi[0]);
        chk(o_lo[k] == (mi[0] && pa < 24'h100000), "R3 low-memory strobe",
            o_lo[k], (mi[0] && pa < 24'h100000));
        chk(o_io[k] == !mi[0], "R9 io strobe without refresh", o_io[k], !mi[0]);
        if (wi[0]) begin
          if (split) begin
            ewd[7:0] = k ? wd[15:8] : wd[7:0];
            chk(o_wd[k][7:0] == ewd[7:0], "R6 split lane", o_wd[k][7:0], ewd[7:0]);
          end else begin
            ewd = zi[0] ? wd : {wd[7:0], wd[7:0]};
            chk(o_wd[k] == ewd, "R6 lane steering", o_wd[k], ewd);
          end
        end
      end
      if (!wi[0]) begin
        if (split) erd = {pat(ea + 24'h1), pat(ea)};
        else if (zi[0]) erd = di[0] ? {pat(ea), pat(ea)} : {pat(ea | 24'h1), pat(ea & ~24'h1)};
        else erd = {8'h00, pat(ea)};
        chk(o_rd == erd, "R7 read result", o_rd, erd);
      end
    end

    // R8: nominal strobe width, then a stretched one
    run_req(1, 0, 0, 0, 24'h012345, 16'h0, 0, 0);
    chk(o_stb == 2, "R8 minimum strobe width", o_stb, 2);
    run_req(1, 0, 0, 0, 24'h012345, 16'h0, 6, 0);
    chk(o_stb == 6, "R8 stretched strobe width", o_stb, 6);
    chk(o_rd == {8'h00, pat(24'h012345)}, "R7 stretched read", o_rd, {8'h00, pat(24'h012345)});

    // R9: refresh blocks I/O strobes; cycle still completes
    run_req(0, 0, 1, 0, 24'h0003F8, 16'h0, 0, 1);
    chk(!o_io[0] && o_done, "R9 io read under refresh", {o_io[0], o_done}, 1);
    run_req(0, 1, 0, 0, 24'h0003F9, 16'h1234, 0, 1);
    chk(!o_io[0] && o_done, "R9 io write under refresh", {o_io[0], o_done}, 1);

    // R10: short hold no flag, long hold flag, next request clears it
    run_req(1, 1, 0, 0, 24'h000400, 16'h00AA, 20, 0);
    chk(!o_tmo, "R10 short hold", 32'(o_tmo), 0);
    run_req(1, 1, 0, 0, 24'h000400, 16'h00AA, 700, 0);
    chk(o_tmo, "R10 long hold", 32'(o_tmo), 1);
    chk(o_stb == 700, "R8 long stretch width", o_stb, 700);
    chk(timeout, "R10 flag persists", 32'(timeout), 1);
    run_req(1, 0, 0, 0, 24'h000400, 16'h0, 0, 0);
    chk(!o_tmo, "R10 cleared by new request", 32'(o_tmo), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule